// File: doc/BRIEF.md
# Audio Serial Transmitter with Free-Space Watermark

This block is the transmit half of a stereo audio serial port. Software writes samples into a 16-entry sample queue through a plain write strobe. A serializer takes the queued samples and shifts them out on a serial data line, together with a bit clock and a word-select line. The block can generate the bit clock itself from the system clock, or it can follow a bit clock and word select driven by another device. Each sample is 16 bits wide, goes out most significant bit first, and fills one channel slot. Left and right channels alternate in the order the samples were queued.

Two framings are available: the classic one-bit-delayed framing and left-justified framing. Software can read the number of free queue slots at any time, flush the queue, and pick a free-space watermark. When the free space reaches that watermark, an interrupt is raised so the queue can be refilled. If the queue runs dry, the serializer sends silence and keeps the frame timing intact.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset, a soft reset (`soft_rst`) or a flush (`tx_clear`), `free_cnt` reads 16 on the following cycle. A flush takes priority over a write in the same cycle.
- R2: With `in_wide`=0, each write queues the single sample `wr_data[15:0]` and uses one slot. A write while `free_cnt`=0 is dropped, and `free_cnt` stays 0.
- R3: With `in_wide`=1, each write queues two samples: first `wr_data[31:16]`, then `wr_data[15:0]`. The write uses two slots. If fewer than two slots are free, the whole write is dropped.
- R4: `free_cnt` equals 16 minus the number of queued samples and never exceeds 16. It changes in the cycle after the write edge.
- R5: `tx_irq` is high exactly when `irq_en`=1, `wm_code`≠0 and `free_cnt` ≥ 4×`wm_code` (code 1 = 4 slots, 2 = 8, 3 = 12). Code 0 never raises it.
- R6: When `bus_fmt[1]`=1 (left-justified, code 2), a sample's MSB is on `sd_out` during the same bit period in which `ws_out` changes. The remaining bits follow MSB first.
- R7: When `bus_fmt[1]`=0 (delayed, code 0), the MSB appears one bit period after the `ws_out` change. The LSB of each sample falls in the first bit period of the next slot.
- R8: `ws_out` is low for left-channel slots and high for right-channel slots, and each slot lasts 16 bit clocks. Queued samples fill slots in queue order, starting with a left slot.
- R9: When a slot starts and the queue is empty, the slot carries all zeros, and `ws_out` keeps alternating every 16 bit clocks.
- R10: With `master_sel`=1 and `tx_en`=1, `sck_out` has a period of 2×HALF_DIV system clocks (20 ns by default). `ws_out` and `sd_out` change only with a falling edge of `sck_out`. While `tx_en`=0, `sck_out` is low and `ws_out` is high.
- R11: With `master_sel`=0, `sck_out` stays low and bit timing follows `sck_in`. Data advances a few system clocks after each falling edge of `sck_in`, and slot boundaries re-align to transitions of `ws_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset of queue and serializer |
| tx_en | input | 1 | Runs the serializer; 0 holds it idle |
| master_sel | input | 1 | 1 = generate bit clock, 0 = follow `sck_in`/`ws_in` |
| bus_fmt | input | 2 | Framing code; bit 1 set = left-justified, clear = one-bit delayed |
| in_wide | input | 1 | 0 = one sample per write, 1 = two samples per write |
| wm_code | input | 2 | Free-space watermark code (0 off, 1/2/3 = 4/8/12 slots) |
| irq_en | input | 1 | Interrupt enable |
| tx_clear | input | 1 | Flushes the queue |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| sck_in | input | 1 | External bit clock (follower mode) |
| ws_in | input | 1 | External word select (follower mode) |
| free_cnt | output | 6 | Free queue slots, 0 to 16 |
| tx_irq | output | 1 | Watermark interrupt |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Word select |
| sd_out | output | 1 | Serial data |

## Verification
Queue status is registered. `free_cnt` and `tx_irq` are therefore sampled at the falling clock edge that follows the single rising edge on which a write, flush or reset took effect, and compared with a bench occupancy model. Serial data is checked the way a receiver would check it. In generator mode, the bench samples `ws_out` and `sd_out` at each rising edge of `sck_out`, half a bit period after they change. In follower mode, the bench samples just before its next falling edge of `sck_in`, which is well after the two-stage synchronizer and the output register have settled. Words are reassembled by framing rules alone and compared in order with the queued samples, with zeros after underflow.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
   // framing selected by bit 1 of the format code
   typedef enum logic {
      FRAME_DELAYED = 1'b0,
      FRAME_LEFT    = 1'b1
   } frame_e;

   function automatic frame_e decode_frame(input logic [1:0] code);
      return frame_e'(code[1]);
   endfunction

   // free-slot threshold for a watermark code
   function automatic int unsigned wm_slots(input logic [1:0] code, input int unsigned step);
      return int'(code) * step;
   endfunction
endpackage

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push_one,
   input  logic          push_two,
   input  logic [W-1:0]  din_a,
   input  logic [W-1:0]  din_b,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          acc_one, acc_two, pop_ok;
   logic [CW-1:0] inc, dec;

   assign empty   = (count == '0);
   assign acc_one = push_one && (count < CW'(DEPTH));
   assign acc_two = push_two && !push_one && (count <= CW'(DEPTH - 2));
   assign pop_ok  = pop && !empty;
   assign inc     = acc_two ? CW'(2) : (acc_one ? CW'(1) : '0);
   assign dec     = pop_ok ? CW'(1) : '0;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (acc_one)      wp <= wp + AW'(1);
         else if (acc_two) wp <= wp + AW'(2);
         if (pop_ok)       rp <= rp + AW'(1);
         count <= count + inc - dec;
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (acc_one) mem[wp] <= din_a;
         if (acc_two) begin
            mem[wp]          <= din_a;
            mem[wp + AW'(1)] <= din_b;
         end
      end
   end
endmodule

// File: rtl/tx_bit_clock.sv
module tx_bit_clock #(
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic master,
   input  logic sck_ext,
   input  logic ws_ext,
   output logic tick,
   output logic sck_o,
   output logic ws_sync
);
   logic [SYNC_STAGES-1:0] sck_chain, ws_chain;
   logic                   sck_prev;
   logic [DW-1:0]          div;
   logic                   sck_q;
   logic                   div_wrap;

   // synchronizer chain, one stage per generate step
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_chain[i] <= 1'b0;
            ws_chain[i]  <= 1'b1;
         end else begin
            sck_chain[i] <= (i == 0) ? sck_ext : sck_chain[(i == 0) ? 0 : i - 1];
            ws_chain[i]  <= (i == 0) ? ws_ext  : ws_chain[(i == 0) ? 0 : i - 1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_chain[SYNC_STAGES-1];
   end

   assign div_wrap = (div == DW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div   <= '0;
         sck_q <= 1'b0;
      end else if (clr || !run || !master) begin
         div   <= '0;
         sck_q <= 1'b0;
      end else if (div_wrap) begin
         div   <= '0;
         sck_q <= ~sck_q;
      end else begin
         div   <= div + DW'(1);
      end
   end

   assign sck_o   = sck_q;
   assign ws_sync = ws_chain[SYNC_STAGES-1];
   assign tick    = run && !clr && (master ? (div_wrap && sck_q)
                                           : (sck_prev && !sck_chain[SYNC_STAGES-1]));
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
   parameter int unsigned W = 16,
   localparam int unsigned CW = $clog2(W) + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         slave,
   input  logic         tick,
   input  logic         ws_ext,
   input  logic         left_just,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_data,
   output logic         pop,
   output logic         ws_o,
   output logic         sd_o
);
   logic [CW-1:0] cnt, cnt_n;
   logic [W-1:0]  sh;
   logic          ws_q;
   logic          load;

   // slot position counter: top bit is the channel, low bits the bit index
   always_comb begin
      if (slave && (ws_ext != ws_q)) cnt_n = {ws_ext, {(CW-1){1'b0}}};
      else                           cnt_n = cnt + CW'(1);
   end

   assign load = left_just ? (cnt_n[CW-2:0] == '0)
                           : (cnt_n[CW-2:0] == (CW-1)'(1));
   assign pop  = run && !clr && tick && load && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '1;
         sh   <= '0;
         ws_q <= 1'b1;
      end else if (clr || !run) begin
         cnt  <= '1;
         sh   <= '0;
         ws_q <= 1'b1;
      end else if (tick) begin
         cnt  <= cnt_n;
         ws_q <= cnt_n[CW-1];
         if (load) sh <= fifo_empty ? '0 : fifo_data;
         else      sh <= {sh[W-2:0], 1'b0};
      end
   end

   assign ws_o = ws_q;
   assign sd_o = sh[W-1];
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
   import audio_tx_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned WM_STEP     = 4,
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FREE_W      = 6,
   localparam int unsigned WORD_W     = 2 * SAMPLE_W,
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              tx_en,
   input  logic              master_sel,
   input  logic [1:0]        bus_fmt,
   input  logic              in_wide,
   input  logic [1:0]        wm_code,
   input  logic              irq_en,
   input  logic              tx_clear,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              sck_in,
   input  logic              ws_in,
   output logic [FREE_W-1:0] free_cnt,
   output logic              tx_irq,
   output logic              sck_out,
   output logic              ws_out,
   output logic              sd_out
);
   // elaboration checks on the parameter set
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DEPTH >= (1 << FREE_W)) begin : g_bad_free
      $error("FREE_W too narrow for DEPTH");
   end
   if (3 * WM_STEP > DEPTH) begin : g_bad_wm
      $error("highest watermark exceeds DEPTH");
   end
   if ((SAMPLE_W & (SAMPLE_W - 1)) != 0 || SAMPLE_W < 2) begin : g_bad_w
      $error("SAMPLE_W must be a power of two");
   end
   if (HALF_DIV < 1 || SYNC_STAGES < 2) begin : g_bad_clk
      $error("HALF_DIV >= 1 and SYNC_STAGES >= 2 required");
   end

   logic                flush;
   logic                run;
   logic [SAMPLE_W-1:0] fifo_dout;
   logic [CW-1:0]       occ;
   logic                fifo_empty;
   logic                pop;
   logic                tick;
   logic                ws_sync;
   logic [FREE_W-1:0]   free_w;
   logic [FREE_W-1:0]   thr;
   frame_e              frame;

   assign flush = tx_clear || soft_rst;
   assign run   = tx_en;
   assign frame = decode_frame(bus_fmt);

   tx_sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push_one (wr_en && !in_wide),
      .push_two (wr_en && in_wide),
      .din_a    (in_wide ? wr_data[WORD_W-1:SAMPLE_W] : wr_data[SAMPLE_W-1:0]),
      .din_b    (wr_data[SAMPLE_W-1:0]),
      .pop      (pop),
      .dout     (fifo_dout),
      .count    (occ),
      .empty    (fifo_empty)
   );

   tx_bit_clock #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_rst),
      .run     (run),
      .master  (master_sel),
      .sck_ext (sck_in),
      .ws_ext  (ws_in),
      .tick    (tick),
      .sck_o   (sck_out),
      .ws_sync (ws_sync)
   );

   tx_frame_shifter #(.W(SAMPLE_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_rst),
      .run        (run),
      .slave      (!master_sel),
      .tick       (tick),
      .ws_ext     (ws_sync),
      .left_just  (frame == FRAME_LEFT),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_dout),
      .pop        (pop),
      .ws_o       (ws_out),
      .sd_o       (sd_out)
   );

   assign free_w   = FREE_W'(DEPTH) - FREE_W'(occ);
   assign thr      = FREE_W'(wm_slots(wm_code, WM_STEP));
   assign free_cnt = free_w;
   assign tx_irq   = irq_en && (wm_code != 2'd0) && (free_w >= thr);
endmodule

// File: rtl/audio_tx_checker.sv
module audio_tx_checker #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned FREE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              tx_en,
   input logic              master_sel,
   input logic              in_wide,
   input logic [1:0]        wm_code,
   input logic              irq_en,
   input logic              tx_clear,
   input logic              wr_en,
   input logic [FREE_W-1:0] free_cnt,
   input logic              tx_irq,
   input logic              sck_out,
   input logic              ws_out
);
   assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_clear || soft_rst) |=> (free_cnt == FREE_W'(DEPTH)));

   assert_narrow_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && wr_en && !in_wide && free_cnt == '0 && !tx_clear && !soft_rst)
      |=> (free_cnt == '0));

   assert_wide_short_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && wr_en && in_wide && free_cnt == FREE_W'(1) && !tx_clear && !soft_rst)
      |=> (free_cnt == FREE_W'(1)));

   assert_free_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= FREE_W'(DEPTH));

   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (irq_en && wm_code != 2'd0));

   assert_ws_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && master_sel && $past(master_sel)
       && !soft_rst && !$past(soft_rst) && !$stable(ws_out)) |-> $fell(sck_out));

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !$past(tx_en)) |-> (!sck_out && ws_out));

   assert_follower_no_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_sel && !$past(master_sel)) |-> !sck_out);
endmodule

bind audio_serial_tx audio_tx_checker #(.DEPTH(DEPTH), .FREE_W(FREE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .tx_en      (tx_en),
   .master_sel (master_sel),
   .in_wide    (in_wide),
   .wm_code    (wm_code),
   .irq_en     (irq_en),
   .tx_clear   (tx_clear),
   .wr_en      (wr_en),
   .free_cnt   (free_cnt),
   .tx_irq     (tx_irq),
   .sck_out    (sck_out),
   .ws_out     (ws_out)
);

// File: tb/audio_serial_tx_test.sv
`timescale 1ns/1ps
module audio_serial_tx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, tx_en = 1'b0, master_sel = 1'b1, in_wide = 1'b0;
   logic [1:0]  bus_fmt = 2'd0, wm_code = 2'd0;
   logic        irq_en = 1'b0, tx_clear = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        sck_in = 1'b1, ws_in = 1'b1;
   logic [5:0]  free_cnt;
   logic        tx_irq, sck_out, ws_out, sd_out;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   audio_serial_tx uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en),
      .master_sel(master_sel), .bus_fmt(bus_fmt), .in_wide(in_wide),
      .wm_code(wm_code), .irq_en(irq_en), .tx_clear(tx_clear),
      .wr_en(wr_en), .wr_data(wr_data), .sck_in(sck_in), .ws_in(ws_in),
      .free_cnt(free_cnt), .tx_irq(tx_irq), .sck_out(sck_out),
      .ws_out(ws_out), .sd_out(sd_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- receiver model ----------------
   logic [15:0] rx_w [64];
   bit          rx_c [64];
   int          rx_n, rx_k, slot_len;
   bit          seen_chg, prev_ws, cur_ch, cap_lj, cap_on;
   logic [15:0] acc;
   logic [15:0] exp_w [64];
   int          exp_n;

   task automatic rx_reset(input bit lj);
      rx_n = 0; rx_k = 1000; slot_len = 0; seen_chg = 0;
      prev_ws = 1'b1; cap_lj = lj; acc = '0;
   endtask

   task automatic rx_consume(input logic d);
      if (rx_k >= 0 && rx_k < 16) begin
         acc = {acc[14:0], d};
         if (rx_k == 15 && rx_n < 64) begin
            rx_w[rx_n] = acc;
            rx_c[rx_n] = cur_ch;
            rx_n++;
         end
      end
      if (rx_k < 1000) rx_k++;
   endtask

   task automatic rx_bit(input logic w, input logic d);
      bit chg;
      chg = (w != prev_ws);
      if (chg) begin
         if (seen_chg) chk(slot_len == 16, "R8 slot length", slot_len, 16);
         seen_chg = 1; slot_len = 0;
      end
      slot_len++;
      if (cap_lj) begin
         if (chg) begin rx_k = 0; cur_ch = w; prev_ws = w; end
         rx_consume(d);
      end else begin
         rx_consume(d);
         if (chg) begin rx_k = 0; cur_ch = w; prev_ws = w; end
      end
   endtask

   always @(posedge sck_out) if (cap_on) rx_bit(ws_out, sd_out);

   task automatic check_stream(input int t, input string tag);
      chk(rx_n >= t, {tag, " word count"}, rx_n, t);
      for (int i = 0; i < t && i < rx_n; i++) begin
         if (i < exp_n) chk(rx_w[i] == exp_w[i], tag, int'(rx_w[i]), int'(exp_w[i]));
         else           chk(rx_w[i] == 16'h0, "R9 underflow zero", int'(rx_w[i]), 0);
         chk(rx_c[i] == bit'(i % 2), "R8 channel order", int'(rx_c[i]), i % 2);
      end
   endtask

   // ---------------- write helpers ----------------
   task automatic push(input bit wide, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; in_wide = wide; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic flush_q();
      @(negedge clk); tx_clear = 1;
      @(negedge clk); tx_clear = 0;
   endtask

   task automatic wait_words(input int t);
      for (int i = 0; i < 20000 && rx_n < t; i++) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int occ;
   int thr;
   bit exp_irq;

   initial begin
      void'($urandom(32'h5EED_0042));
      cap_on = 0;
      rx_reset(1);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(free_cnt == 6'd16, "R1 reset free", free_cnt, 16);
      chk(tx_irq == 1'b0, "R5 reset irq", tx_irq, 0);
      chk(sck_out == 1'b0 && ws_out == 1'b1, "R10 idle lines", {sck_out, ws_out}, 1);

      // ---- random queue/status phase (serializer idle) ----
      occ = 0;
      for (int n = 0; n < 300; n++) begin
         int op;
         op = int'($urandom_range(0, 99));
         @(negedge clk);
         wr_en = 0; tx_clear = 0; soft_rst = 0;
         irq_en = 1'($urandom_range(0, 1));
         wm_code = 2'($urandom_range(0, 3));
         wr_data = $urandom();
         in_wide = 1'($urandom_range(0, 1));
         if (op < 70) wr_en = 1;
         if (op >= 70 && op < 76) tx_clear = 1;
         if (op == 76) soft_rst = 1;
         if (op == 77) begin wr_en = 1; tx_clear = 1; end
         if (tx_clear || soft_rst) occ = 0;
         else if (wr_en && !in_wide) begin if (occ < 16) occ++; end
         else if (wr_en && in_wide)  begin if (occ <= 14) occ += 2; end
         @(negedge clk);
         wr_en = 0; tx_clear = 0; soft_rst = 0;
         thr = 4 * int'(wm_code);
         exp_irq = irq_en && wm_code != 0 && (16 - occ) >= thr;
         if (op == 77) chk(free_cnt == 6'd16, "R1 clear beats write", free_cnt, 16);
         else if (in_wide) chk(free_cnt == 6'(16 - occ), "R3 wide free", free_cnt, 16 - occ);
         else chk(free_cnt == 6'(16 - occ), "R4 free count", free_cnt, 16 - occ);
         chk(tx_irq == exp_irq, "R5 watermark irq", tx_irq, int'(exp_irq));
      end
      irq_en = 0; wm_code = 0;

      // ---- left-justified stream, full queue plus a dropped write ----
      flush_q();
      exp_n = 0;
      for (int i = 0; i < 16; i++) begin
         exp_w[i] = 16'($urandom());
         push(0, {16'hFFFF, exp_w[i]});
         exp_n++;
      end
      push(0, 32'h0000_DEAD);
      @(negedge clk);
      chk(free_cnt == 6'd0, "R2 full drop", free_cnt, 0);
      bus_fmt = 2'd2; master_sel = 1; rx_reset(1); cap_on = 1;
      tx_en = 1;
      wait_words(19);
      tx_en = 0; cap_on = 0;
      check_stream(19, "R6 left-justified data");

      // ---- delayed framing with wide writes ----
      flush_q();
      exp_n = 0;
      for (int i = 0; i < 7; i++) begin
         logic [31:0] d;
         d = $urandom();
         exp_w[exp_n] = d[31:16]; exp_w[exp_n+1] = d[15:0]; exp_n += 2;
         push(1, d);
      end
      exp_w[exp_n] = 16'h8001; exp_n++;
      push(0, 32'h0000_8001);
      push(1, 32'h1234_5678);
      @(negedge clk);
      chk(free_cnt == 6'd1, "R3 wide short drop", free_cnt, 1);
      exp_w[exp_n] = 16'h7FFE; exp_n++;
      push(0, 32'h0000_7FFE);
      bus_fmt = 2'd0; rx_reset(0); cap_on = 1;
      tx_en = 1;
      wait_words(19);
      tx_en = 0; cap_on = 0;
      check_stream(19, "R7 delayed data");

      // ---- generated bit clock period ----
      begin
         realtime t0, t1;
         tx_en = 1;
         @(posedge sck_out); t0 = $realtime;
         @(posedge sck_out); t1 = $realtime;
         chk((t1 - t0) > 19.9 && (t1 - t0) < 20.1, "R10 sck period",
             int'(t1 - t0), 20);
         @(negedge clk); tx_en = 0;
         @(negedge clk); @(negedge clk);
         chk(sck_out == 1'b0 && ws_out == 1'b1, "R10 idle after stop", {sck_out, ws_out}, 1);
      end

      // ---- follower mode, left-justified ----
      flush_q();
      master_sel = 0; bus_fmt = 2'd2;
      exp_n = 0;
      for (int i = 0; i < 4; i++) begin
         exp_w[i] = 16'($urandom()); exp_n++;
         push(0, {16'h0, exp_w[i]});
      end
      sck_in = 1; ws_in = 1;
      repeat (4) @(negedge clk);
      rx_reset(1);
      tx_en = 1;
      repeat (2) @(negedge clk);
      for (int b = 0; b < 96; b++) begin
         sck_in = 0; ws_in = 1'((b / 16) % 2);
         repeat (8) @(negedge clk);
         sck_in = 1;
         repeat (8) @(negedge clk);
         chk(sck_out == 1'b0, "R11 no generated clock", sck_out, 0);
         rx_bit(ws_in, sd_out);
      end
      tx_en = 0;
      check_stream(6, "R11 follower data");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule